// File: doc/BRIEF.md
# Parameter Safeload Update Controller

This block sits in front of the single write port of a coefficient RAM that feeds a fixed-point audio datapath. A host writes coefficients one byte at a time into shadow registers, together with a RAM start address and a slot count. It then writes a one-bit update strobe. After the strobe the block copies the staged coefficients into consecutive RAM words as one group. The running filter therefore never sees a half-written coefficient set.

The RAM write port has three requesters: a direct control-port write path, an embedded processor write path, and the safeload engine. The control port always wins. A processor write in the same cycle as a control-port write is discarded. The safeload engine writes only in cycles that neither of the other two uses. A busy flag covers the commit, and a one-cycle done pulse marks its end.

Top module: `coef_safeload`

## Requirements
- R1: A host write with `hst_sel = 3*s + b` (s = 0..4, b = 0..2) loads byte b of staged slot s. Byte 0 is bits [7:0], byte 1 is bits [15:8] and byte 2 is bits [23:16]. Slot 0 is the first coefficient committed.
- R2: After a commit of n slots, RAM word `start + i` (modulo 1024) holds slot i for every i < n, and exactly n safeload writes occur. The start address is set by writes to `hst_sel` 15 (bits [7:0]) and 16 (bits [9:8] taken from data bits [1:0]).
- R3: The slot count is written at `hst_sel` 17, data bits [2:0]. A count of 0 launches nothing: busy stays low, no done pulse appears and no RAM write occurs. A count of 6 or 7 commits 5 slots.
- R4: Writing data bit 0 = 1 to `hst_sel` 18 raises busy in the next cycle. With a free port, slot i is presented in the i-th cycle of busy. Busy falls after the last slot is written, and done is high for exactly one cycle as busy falls.
- R5: When `cp_we` is high, the RAM port carries the control-port address and data. A processor write in that cycle is dropped. A processor write alone passes to the RAM port.
- R6: The safeload engine writes only in cycles where neither `cp_we` nor `dsp_we` is high. Blocked cycles stall the commit without losing any slot.
- R7: While busy is high, all host staging writes are ignored, including writes to the slots, address, count and update registers.
- R8: A commit leaves the staged values unchanged, so a second strobe commits the same values again.
- R9: Each 24-bit staged value reaches the RAM as a 28-bit word sign-extended from bit 23.
- R10: After reset, busy, done and `ram_we` are low, and the staged slots, address and count are zero.
- R11: An update write with data bit 0 = 0 launches no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host staging register write strobe |
| hst_sel | input | 5 | Host staging register select |
| hst_data | input | 8 | Host staging write byte |
| cp_we | input | 1 | Control-port direct RAM write enable |
| cp_addr | input | 10 | Control-port RAM address |
| cp_data | input | 28 | Control-port RAM data |
| dsp_we | input | 1 | Processor RAM write enable |
| dsp_addr | input | 10 | Processor RAM address |
| dsp_data | input | 28 | Processor RAM data |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 10 | RAM write address |
| ram_wdata | output | 28 | RAM write data |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle commit-complete pulse |

## Verification
The hardest case to reach is a commit that is stalled partway through by other requesters while the host also tries to change the staging registers. The commit must still land every slot with its original value, and the slot counter must neither skip nor repeat a slot. Random rounds therefore inject control-port and processor writes into random cycles of each commit. Directed cases hold the processor write across the first slots and rewrite slot 0 and the count during busy. A later re-commit without fresh staging then exposes any value the ignored writes altered.

// File: rtl/coef_safeload.sv
module coef_safeload #(
  parameter int AW    = 10,
  parameter int DW    = 28,
  parameter int SW    = 24,
  parameter int NSLOT = 5,
  parameter int SELW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_wr,
  input  logic [SELW-1:0] hst_sel,
  input  logic [7:0]      hst_data,
  input  logic            cp_we,
  input  logic [AW-1:0]   cp_addr,
  input  logic [DW-1:0]   cp_data,
  input  logic            dsp_we,
  input  logic [AW-1:0]   dsp_addr,
  input  logic [DW-1:0]   dsp_data,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            busy,
  output logic            done
);
  localparam int NB      = SW / 8;
  localparam int CW      = $clog2(NSLOT + 1);
  localparam int IW      = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int SEL_ALO = NSLOT * NB;
  localparam int SEL_AHI = SEL_ALO + 1;
  localparam int SEL_CNT = SEL_ALO + 2;
  localparam int SEL_UPD = SEL_ALO + 3;

  logic [SW-1:0] slot_q [NSLOT];
  logic [AW-1:0] start_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  wire            stage_wr = hst_wr & ~busy;
  wire [CW-1:0]   cnt_eff  = (cnt_q > CW'(NSLOT)) ? CW'(NSLOT) : cnt_q;
  wire            launch   = stage_wr && (hst_sel == SELW'(SEL_UPD)) && hst_data[0] && (cnt_eff != '0);
  wire            sl_slot  = busy & ~cp_we & ~dsp_we;
  wire            sl_last  = ({{(CW > IW ? 1 : IW - CW + 1){1'b0}}, idx_q} + 1'b1) ==
                             {{(IW > CW ? 1 : CW - IW + 1){1'b0}}, cnt_eff};
  wire [SW-1:0]   sl_val   = slot_q[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (stage_wr) begin
      for (int s = 0; s < NSLOT; s++)
        for (int b = 0; b < NB; b++)
          if (hst_sel == SELW'(s * NB + b)) slot_q[s][b*8 +: 8] <= hst_data;
      if (hst_sel == SELW'(SEL_ALO)) start_q[7:0]    <= hst_data;
      if (hst_sel == SELW'(SEL_AHI)) start_q[AW-1:8] <= hst_data[AW-9:0];
      if (hst_sel == SELW'(SEL_CNT)) cnt_q           <= hst_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx_q <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        idx_q <= '0;
      end else if (sl_slot) begin
        if (sl_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign ram_we    = cp_we | dsp_we | busy;
  assign ram_addr  = cp_we  ? cp_addr  :
                     dsp_we ? dsp_addr : start_q + AW'(idx_q);
  assign ram_wdata = cp_we  ? cp_data  :
                     dsp_we ? dsp_data : {{(DW-SW){sl_val[SW-1]}}, sl_val};
endmodule

// File: rtl/coef_safeload_chk.sv
module coef_safeload_chk #(
  parameter int AW = 10,
  parameter int DW = 28,
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cp_we,
  input logic [AW-1:0] cp_addr,
  input logic [DW-1:0] cp_data,
  input logic          dsp_we,
  input logic [AW-1:0] dsp_addr,
  input logic [DW-1:0] dsp_data,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          busy,
  input logic          done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R4
  AST_CP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    cp_we |-> (ram_we && ram_addr == cp_addr && ram_wdata == cp_data)); // R5
  AST_DSP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_we && !cp_we) |-> (ram_we && ram_addr == dsp_addr && ram_wdata == dsp_data)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cp_we && !dsp_we) |-> !ram_we); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cp_we || dsp_we)) |=> busy); // R6
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cp_we && !dsp_we) |-> (ram_wdata[DW-1:SW-1] == '0 || ram_wdata[DW-1:SW-1] == '1)); // R9
endmodule

bind coef_safeload coef_safeload_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cp_we(cp_we), .cp_addr(cp_addr), .cp_data(cp_data),
  .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .busy(busy), .done(done)
);

// File: tb/test_coef_safeload.sv
module test_coef_safeload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic [4:0]  hst_sel = '0;
  logic [7:0]  hst_data = '0;
  logic        cp_we = 1'b0, dsp_we = 1'b0;
  logic [9:0]  cp_addr = '0, dsp_addr = '0;
  logic [27:0] cp_data = '0, dsp_data = '0;
  logic        ram_we, busy, done;
  logic [9:0]  ram_addr;
  logic [27:0] ram_wdata;

  int checks = 0, errors = 0, sl_writes = 0;
  logic [27:0] mem [1024];
  logic [23:0] stg [5];

  always #10 clk = ~clk;

  coef_safeload i_coef_safeload (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_sel(hst_sel), .hst_data(hst_data),
    .cp_we(cp_we), .cp_addr(cp_addr), .cp_data(cp_data),
    .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .busy(busy), .done(done));

  always @(posedge clk) if (ram_we) begin
    mem[ram_addr] <= ram_wdata;
    if (!cp_we && !dsp_we) sl_writes <= sl_writes + 1;
  end

  function automatic logic [27:0] sext(input logic [23:0] v);
    return {{4{v[23]}}, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int sel, input logic [7:0] d);
    hst_wr = 1'b1; hst_sel = 5'(sel); hst_data = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic stage_slot(input int s, input logic [23:0] v);
    for (int b = 0; b < 3; b++) hwrite(3*s + b, v[8*b +: 8]);
    stg[s] = v;
  endtask

  task automatic start_commit(input logic [9:0] a, input int cnt);
    hwrite(15, a[7:0]);
    hwrite(16, {6'b0, a[9:8]});
    hwrite(17, 8'(cnt));
    hwrite(18, 8'h01);
  endtask

  task automatic wait_done(input bit noise, output int cyc);
    cyc = 0;
    while (!done && cyc < 300) begin
      if (noise) begin
        dsp_we = ($urandom % 4) == 0; dsp_addr = 10'h3F0 + 10'($urandom % 16); dsp_data = 28'($urandom);
        cp_we = ($urandom % 8) == 0;  cp_addr = 10'h3F0 + 10'($urandom % 16);  cp_data = 28'($urandom);
      end
      @(negedge clk);
      cyc++;
    end
    cp_we = 1'b0; dsp_we = 1'b0;
    check(done, "R4 done pulse seen", 32'(done), 1);
    @(negedge clk);
    check(!done && !busy, "R4 done one cycle, busy low", {busy, done}, 0);
  endtask

  task automatic check_region(input logic [9:0] a, input int n, input string req);
    for (int i = 0; i < n; i++)
      check(mem[10'(a + 10'(i))] === sext(stg[i]), req, 32'(mem[10'(a + 10'(i))]), 32'(sext(stg[i])));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, base, n;
    logic [9:0] a;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(!busy && !done && !ram_we, "R10 reset outputs", {ram_we, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: staged zeros commit as zeros
    hwrite(17, 8'd1); hwrite(18, 8'h01);
    check(ram_we && ram_addr == 10'h000 && ram_wdata == 28'h0, "R10 zero staging", ram_wdata, 0);
    for (int s = 0; s < 5; s++) stg[s] = '0;
    wait_done(1'b0, cyc);

    // R1 R2 R4 R9: directed commit of 3 with negative values
    stage_slot(0, 24'h800001); stage_slot(1, 24'h123456); stage_slot(2, 24'hFEDCBA);
    stage_slot(3, 24'h0A0B0C); stage_slot(4, 24'h7FFFFF);
    base = sl_writes;
    start_commit(10'h020, 3);
    check(busy && ram_we && ram_addr == 10'h020, "R4 busy after strobe, slot0 presented", {busy, ram_addr}, {1'b1, 10'h020});
    check(ram_wdata == 28'hF800001, "R9 sign extension on port", ram_wdata, 28'hF800001);
    wait_done(1'b0, cyc);
    check(cyc == 3, "R4 done timing", cyc, 3);
    check(sl_writes - base == 3, "R2 write count", sl_writes - base, 3);
    check_region(10'h020, 3, "R1 R2 R9 committed value");

    // R2: address wrap
    base = sl_writes;
    start_commit(10'h3FE, 3);
    wait_done(1'b0, cyc);
    check_region(10'h3FE, 3, "R2 wrap value");
    check(sl_writes - base == 3, "R2 wrap count", sl_writes - base, 3);

    // R3: count 0 does nothing
    base = sl_writes;
    start_commit(10'h040, 0);
    repeat (3) begin
      check(!busy && !done && !ram_we, "R3 count zero idle", {ram_we, busy, done}, 0);
      @(negedge clk);
    end
    check(sl_writes == base, "R3 count zero no write", sl_writes - base, 0);
    // R11: update with bit0 clear
    hwrite(17, 8'd2); hwrite(18, 8'h02);
    repeat (2) begin
      check(!busy && !ram_we, "R11 bit0 clear no launch", {ram_we, busy}, 0);
      @(negedge clk);
    end
    // R3: count 7 clamps to 5
    base = sl_writes;
    start_commit(10'h050, 7);
    wait_done(1'b0, cyc);
    check(sl_writes - base == 5, "R3 count clamp", sl_writes - base, 5);
    check_region(10'h050, 5, "R3 clamp values");

    // R5: same-cycle control port and processor
    cp_we = 1'b1; cp_addr = 10'h300; cp_data = 28'h1111111;
    dsp_we = 1'b1; dsp_addr = 10'h301; dsp_data = 28'h2222222;
    #1 check(ram_addr == 10'h300 && ram_wdata == 28'h1111111, "R5 control port wins", ram_addr, 10'h300);
    mem[10'h301] = 28'h5555555;
    @(negedge clk);
    cp_we = 1'b0;
    check(mem[10'h300] == 28'h1111111, "R5 control write landed", mem[10'h300], 28'h1111111);
    check(mem[10'h301] == 28'h5555555, "R5 processor write dropped", mem[10'h301], 28'h5555555);
    @(negedge clk);
    dsp_we = 1'b0;
    check(mem[10'h301] == 28'h2222222, "R5 processor write alone", mem[10'h301], 28'h2222222);

    // R6: processor holds the port for 3 cycles after strobe
    base = sl_writes;
    start_commit(10'h080, 2);
    dsp_we = 1'b1; dsp_addr = 10'h3F5; dsp_data = 28'h0ABCDEF;
    repeat (3) begin
      @(negedge clk);
      check(busy, "R6 busy held while stalled", busy, 1);
    end
    dsp_we = 1'b0;
    check(sl_writes == base, "R6 no safeload write while blocked", sl_writes - base, 0);
    wait_done(1'b0, cyc);
    check(cyc == 2, "R6 resumes after stall", cyc, 2);
    check_region(10'h080, 2, "R6 stalled values");
    check(mem[10'h3F5] == 28'h0ABCDEF, "R6 processor write", mem[10'h3F5], 28'h0ABCDEF);

    // R7 R8: writes during busy ignored, then re-commit
    base = sl_writes;
    start_commit(10'h100, 5);
    hwrite(0, 8'hEE);
    hwrite(17, 8'd1);
    hwrite(15, 8'h77);
    wait_done(1'b0, cyc);
    check_region(10'h100, 5, "R7 values during busy");
    hwrite(18, 8'h01);
    wait_done(1'b0, cyc);
    check(sl_writes - base == 10, "R7 count unchanged", sl_writes - base, 10);
    check_region(10'h100, 5, "R8 re-commit same values");

    // Random rounds with port noise
    for (int it = 0; it < 40; it++) begin
      for (int s = 0; s < 5; s++) if ($urandom % 2) stage_slot(s, 24'($urandom));
      a = 10'($urandom % 'h3E0);
      n = $urandom % 8;
      base = sl_writes;
      start_commit(a, n);
      if (n == 0) begin
        @(negedge clk);
        check(!busy, "R3 random count zero", busy, 0);
      end else begin
        wait_done(1'b1, cyc);
        n = (n > 5) ? 5 : n;
        check(sl_writes - base == n, "R2 random count", sl_writes - base, n);
        check_region(a, n, "R2 R6 random values");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule